// File: doc/BRIEF.md
# Stop-Clock Interrupt Sideband Latch

This block conditions the four event lines that run from the platform to the processor: the non-maskable interrupt, the active-low system-management interrupt, the maskable interrupt request and the soft-init request. It also drives the processor's soft-init and hard-reset pins. A static strap picks one of two processor-family modes. In pass-through mode the event lines reach the processor unchanged in every power state. In latched mode they are frozen while the processor's active-low stop-clock request is in effect.

In latched mode the stop-clock request first passes through a two-flop synchroniser. On the first clock that sees the synchronised request, the event values are captured and the outputs hold them. After the synchronised request is removed, the hold lasts a further fixed number of PCI clocks (five by default), and then the outputs follow their inputs again. If the request comes back during that window, the window starts over and the values already held are kept. The same strap sets the polarity of the soft-init and hard-reset pins: active-high in latched mode, active-low in pass-through mode. The strap value that selects latched mode is a parameter.

Top module: `stpclk_sideband_latch`

## Requirements
- R1: With the strap at pass-through (strap_i = 0 by default), nmi_o, smi_n_o, intr_o and the logical init level follow their inputs in the same cycle, whatever the state of stpclk_n_i.
- R2: In pass-through mode, init_o drives the inverse of init_i and cpurst_o drives the inverse of cpurst_i (active-low pins).
- R3: In latched mode (strap_i = 1 by default), init_o and cpurst_o are active-high: init_o equals the conditioned init level and cpurst_o equals cpurst_i. cpurst_o is never held.
- R4: In latched mode with no stop-clock in effect, the four event outputs follow their inputs in the same cycle.
- R5: In latched mode, stpclk_n_i goes through two synchronising flops. Take the rising edge after the one at which the second flop first reads 0. From that edge on, the event outputs hold the input values sampled at that edge, and later input changes have no effect on them.
- R6: Take the first rising edge at which the synchronised request reads inactive. From that edge the outputs stay held for exactly HOLD_CYCLES (5) further clocks, and then follow their inputs again.
- R7: A synchronised stop-clock request seen during that window clears the window count, keeps the held values without taking a new sample, and restarts the count from zero after the next release.
- R8: While rst_n is low, and in the first cycle after it, the hold is inactive. The outputs then follow the inputs, the held values are cleared to the idle levels (nmi 0, smi_n 1, intr 0, init 0) and the window count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Static mode strap |
| stpclk_n_i | input | 1 | Asynchronous active-low stop-clock request |
| nmi_i | input | 1 | Raw non-maskable interrupt |
| smi_n_i | input | 1 | Raw system-management interrupt, active low |
| intr_i | input | 1 | Raw maskable interrupt request |
| init_i | input | 1 | Raw soft-init request, active high |
| cpurst_i | input | 1 | Raw processor reset request, active high |
| nmi_o | output | 1 | Conditioned non-maskable interrupt |
| smi_n_o | output | 1 | Conditioned system-management interrupt, active low |
| intr_o | output | 1 | Conditioned maskable interrupt |
| init_o | output | 1 | Soft-init pin at the strap-selected polarity |
| cpurst_o | output | 1 | Processor reset pin at the strap-selected polarity |

## Verification
The bench aims at the cycle edges of the hold. A synchroniser that is one flop short or one flop long freezes the outputs one cycle early or one cycle late. A release count that is off by one lets the events through one clock too soon or too late. The bench brings the stop-clock request back at several points inside the release window: a design that took a new sample there would present the newer inputs, and a design that did not clear the count would release early. It also holds stop-clock asserted in pass-through mode, and it flips the strap to check that the polarity swaps on the soft-init and reset pins. A design that latched in the wrong mode, or that held the reset pin, would show stale values there.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
   localparam int EVT_N    = 4;
   localparam int EVT_NMI  = 0;
   localparam int EVT_SMI  = 1;
   localparam int EVT_INTR = 2;
   localparam int EVT_INIT = 3;
   // idle levels of the event vector: only the smi line is active low
   localparam logic [EVT_N-1:0] EVT_IDLE = 4'b0010;

   typedef enum logic [1:0] {
      PH_FOLLOW  = 2'd0,
      PH_HOLD    = 2'd1,
      PH_RELEASE = 2'd2
   } hold_phase_e;
endpackage

// File: rtl/sbl_sync.sv
module sbl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial begin
      if (STAGES < 2) $error("sbl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic src;
      if (g == 0) begin : g_first
         assign src = d_i;
      end else begin : g_next
         assign src = chain[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= RST_VAL;
         else        chain[g] <= src;
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sbl_hold_ctrl.sv
module sbl_hold_ctrl
   import sbl_pkg::*;
#(
   parameter int HOLD_CYCLES = 5,
   localparam int CNT_W      = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES),
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        latch_mode_i,
   input  logic        stop_i,
   output logic        hold_o,
   output logic        load_o
);
   initial begin
      if (HOLD_CYCLES < 1) $error("sbl_hold_ctrl: HOLD_CYCLES must be at least 1");
   end

   hold_phase_e           phase_q, phase_d;
   logic [CNT_W-1:0]      cnt_q, cnt_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_FOLLOW: begin
            if (latch_mode_i && stop_i) phase_d = PH_HOLD;
         end
         PH_HOLD: begin
            if (!latch_mode_i) phase_d = PH_FOLLOW;
            else if (!stop_i)  phase_d = PH_RELEASE;
         end
         PH_RELEASE: begin
            if (!latch_mode_i)          phase_d = PH_FOLLOW;
            else if (stop_i)            phase_d = PH_HOLD;
            else if (cnt_q == CNT_LAST) phase_d = PH_FOLLOW;
         end
         default: phase_d = PH_FOLLOW;
      endcase
   end

   always_comb begin
      if (phase_q == PH_RELEASE && phase_d == PH_RELEASE) cnt_d = cnt_q + 1'b1;
      else                                                 cnt_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FOLLOW;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign hold_o = (phase_q != PH_FOLLOW);
   assign load_o = (phase_q == PH_FOLLOW);

   // R7: a request seen in the release window returns to holding with the count cleared
   a_r7_restart_window: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RELEASE && stop_i && latch_mode_i) |=> (phase_q == PH_HOLD && cnt_q == '0));

   // R6: the window ends on its last count when no request is seen
   a_r6_window_end: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RELEASE && cnt_q == CNT_LAST && !stop_i) |=> (phase_q == PH_FOLLOW));

   // R6: the count stays inside the window
   a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RELEASE) |-> (cnt_q <= CNT_LAST));

   // R1: pass-through mode never enters a hold from the follow phase
   a_r1_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_mode_i && phase_q == PH_FOLLOW) |=> (phase_q == PH_FOLLOW));
endmodule

// File: rtl/sbl_evt_latch.sv
module sbl_evt_latch #(
   parameter int                WIDTH = 4,
   parameter logic [WIDTH-1:0]  IDLE  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      if (WIDTH < 1) $error("sbl_evt_latch: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q_o[b] <= IDLE[b];
         else if (load_i) q_o[b] <= d_i[b];
      end
   end
endmodule

// File: rtl/sbl_pol_drive.sv
module sbl_pol_drive #(
   parameter int WIDTH = 2
) (
   input  logic             act_high_i,
   input  logic [WIDTH-1:0] req_i,
   output logic [WIDTH-1:0] pin_o
);
   initial begin
      if (WIDTH < 1) $error("sbl_pol_drive: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_pin
      assign pin_o[b] = act_high_i ? req_i[b] : ~req_i[b];
   end
endmodule

// File: rtl/stpclk_sideband_latch.sv
module stpclk_sideband_latch
   import sbl_pkg::*;
#(
   parameter int   HOLD_CYCLES     = 5,
   parameter int   SYNC_STAGES     = 2,
   parameter logic LATCH_STRAP_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_i,
   input  logic stpclk_n_i,
   input  logic nmi_i,
   input  logic smi_n_i,
   input  logic intr_i,
   input  logic init_i,
   input  logic cpurst_i,
   output logic nmi_o,
   output logic smi_n_o,
   output logic intr_o,
   output logic init_o,
   output logic cpurst_o
);
   initial begin
      if (HOLD_CYCLES < 1) $error("stpclk_sideband_latch: HOLD_CYCLES must be at least 1");
      if (SYNC_STAGES < 2) $error("stpclk_sideband_latch: SYNC_STAGES must be at least 2");
   end

   logic             latch_mode;
   logic             stpclk_n_s;
   logic             stop_req;
   logic             hold;
   logic             load;
   logic [EVT_N-1:0] evt_in, evt_held, evt_out;
   logic [1:0]       pin_req, pin_drv;

   assign latch_mode = (strap_i == LATCH_STRAP_VAL);

   assign evt_in[EVT_NMI]  = nmi_i;
   assign evt_in[EVT_SMI]  = smi_n_i;
   assign evt_in[EVT_INTR] = intr_i;
   assign evt_in[EVT_INIT] = init_i;

   sbl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (stpclk_n_i),
      .q_o   (stpclk_n_s)
   );
   assign stop_req = ~stpclk_n_s;

   sbl_hold_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .latch_mode_i (latch_mode),
      .stop_i       (stop_req),
      .hold_o       (hold),
      .load_o       (load)
   );

   sbl_evt_latch #(.WIDTH(EVT_N), .IDLE(EVT_IDLE)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .d_i    (evt_in),
      .q_o    (evt_held)
   );

   assign evt_out = hold ? evt_held : evt_in;

   assign nmi_o   = evt_out[EVT_NMI];
   assign smi_n_o = evt_out[EVT_SMI];
   assign intr_o  = evt_out[EVT_INTR];

   assign pin_req = {cpurst_i, evt_out[EVT_INIT]};

   sbl_pol_drive #(.WIDTH(2)) u_pol (
      .act_high_i (latch_mode),
      .req_i      (pin_req),
      .pin_o      (pin_drv)
   );

   assign init_o   = pin_drv[0];
   assign cpurst_o = pin_drv[1];

   // R5: the held values do not move while the hold continues
   a_r5_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $past(hold)) |-> $stable(evt_held));

   // R4: with no hold the event lines equal their inputs
   a_r4_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |-> ({init_i, intr_i, smi_n_i, nmi_i} == {(latch_mode ? init_o : ~init_o), intr_o, smi_n_o, nmi_o}));

   // R2 and R3: the reset pin follows its request at the strap polarity
   a_r3_rst_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      cpurst_o == (latch_mode ? cpurst_i : ~cpurst_i));

   // R8: the first cycle after reset has no hold and idle stored values
   a_r8_reset_idle: assert property (@(posedge clk)
      (!$past(rst_n) && rst_n) |-> (!hold && evt_held == EVT_IDLE));
endmodule

// File: tb/sim_stpclk_sideband_latch.sv
module sim_stpclk_sideband_latch;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap = 1'b1, stpclk_n = 1'b1;
   logic nmi_i = 1'b0, smi_n_i = 1'b1, intr_i = 1'b0, init_i = 1'b0, cpurst_i = 1'b0;
   logic nmi_o, smi_n_o, intr_o, init_o, cpurst_o;

   int    n_chk = 0, n_fail = 0;
   string tag = "R8";

   // reference model state
   int       m_ph = 0;
   int       m_cnt = 0;
   bit [3:0] m_lat = 4'b0010;
   bit       m_s1 = 1'b1, m_s2 = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   stpclk_sideband_latch u0 (
      .clk(clk), .rst_n(rst_n), .strap_i(strap), .stpclk_n_i(stpclk_n),
      .nmi_i(nmi_i), .smi_n_i(smi_n_i), .intr_i(intr_i), .init_i(init_i), .cpurst_i(cpurst_i),
      .nmi_o(nmi_o), .smi_n_o(smi_n_o), .intr_o(intr_o), .init_o(init_o), .cpurst_o(cpurst_o)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_lat = 4'b0010; m_s1 = 1'b1; m_s2 = 1'b1;
      end else begin
         bit stop, mode;
         stop = !m_s2;
         mode = (strap == 1'b1);
         case (m_ph)
            0: begin
               m_lat = {init_i, intr_i, smi_n_i, nmi_i};
               if (mode && stop) m_ph = 1;
            end
            1: begin
               if (!mode) m_ph = 0;
               else if (!stop) begin m_ph = 2; m_cnt = 0; end
            end
            default: begin
               if (!mode) m_ph = 0;
               else if (stop) m_ph = 1;
               else if (m_cnt == HOLD-1) m_ph = 0;
               else m_cnt++;
            end
         endcase
         m_s2 = m_s1;
         m_s1 = stpclk_n;
      end
   end

   task automatic compare();
      bit [3:0] ev;
      bit [4:0] exp_v, act_v;
      bit       mode;
      mode  = (strap == 1'b1);
      ev    = (m_ph != 0) ? m_lat : {init_i, intr_i, smi_n_i, nmi_i};
      exp_v = {(mode ? cpurst_i : ~cpurst_i), (mode ? ev[3] : ~ev[3]), ev[2], ev[1], ev[0]};
      act_v = {cpurst_o, init_o, intr_o, smi_n_o, nmi_o};
      n_chk++;
      if (act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s at %0t: {cpurst,init,intr,smi_n,nmi} actual %b expected %b",
                  tag, $time, act_v, exp_v);
      end
   endtask

   task automatic cyc(input string t, input logic s_n, input bit rnd);
      @(negedge clk);
      tag = t;
      stpclk_n = s_n;
      if (rnd) {cpurst_i, init_i, intr_i, smi_n_i, nmi_i} = 5'($urandom);
      #1 compare();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R8: reset and the first cycles after it
      for (int i = 0; i < 3; i++) cyc("R8", 1'b1, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      for (int i = 0; i < 2; i++) cyc("R8", 1'b1, 1'b1);
      // R4 and R3: latched mode, no stop-clock
      for (int i = 0; i < 10; i++) cyc("R4", 1'b1, 1'b1);
      // R5: stop-clock asserted, inputs keep changing
      for (int i = 0; i < 12; i++) cyc("R5", 1'b0, 1'b1);
      // R6: release and the hold window
      for (int i = 0; i < 12; i++) cyc("R6", 1'b1, 1'b1);
      // R7: reassert at each point of the window
      for (int gap = 1; gap <= HOLD + 3; gap++) begin
         for (int i = 0; i < 4; i++) cyc("R7", 1'b0, 1'b1);
         for (int i = 0; i < gap; i++) cyc("R7", 1'b1, 1'b1);
         for (int i = 0; i < 3; i++) cyc("R7", 1'b0, 1'b1);
         for (int i = 0; i < 12; i++) cyc("R7", 1'b1, 1'b1);
      end
      // R1 and R2: pass-through with stop-clock toggling
      strap = 1'b0;
      for (int i = 0; i < 30; i++) cyc("R1", (i % 10) < 6 ? 1'b0 : 1'b1, 1'b1);
      for (int i = 0; i < 8; i++) cyc("R2", 1'b1, 1'b1);
      // R3: back to latched mode, polarity and a further hold
      strap = 1'b1;
      for (int i = 0; i < 8; i++) cyc("R3", 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) cyc("R3", 1'b0, 1'b1);
      for (int i = 0; i < 10; i++) cyc("R3", 1'b1, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule